// File: doc/BRIEF.md
# Serial Chain Configuration Loader

This block is the receiving end of a bit-serial configuration link, built to sit at any position in a chain of identical receivers. Every clock it samples one bit from `ser_in`. Before the start pattern `0010` has appeared, it treats the line as idle. After the pattern comes a 24-bit total clock count. The block copies the whole header, pattern and count included, to `ser_out` with one clock of delay. The next receiver in the chain can therefore parse the same header.

After the header, the block takes its own fixed number of frames. Each frame is a zero start bit followed by `FRAME_BITS` data bits. Each finished frame is presented on a parallel port with a one-clock strobe. While its own frames are being taken, `ser_out` stays high. Once its quota is met, every later bit is copied to `ser_out` with one clock of delay, so downstream receivers get their frames.

From the release of reset, the block counts every clock. When the count reaches the captured total, it enters a three-step start-up: first `seq_start`, then one clock later `cfg_finished`, then one more clock later `io_free`. All receivers on a shared count therefore come up on the same clock. After that, the input is ignored.

Top module: `serial_chain_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to the idle search state: `ser_out` is 1, and `frame_vld`, `seq_start`, `cfg_finished` and `io_free` are 0. This holds even if start-up had already begun.
- R2: No header is accepted until the last four sampled bits, oldest first, are 0,0,1,0. Until then, and for the four pattern bits themselves, `ser_out` equals the bit sampled one clock earlier.
- R3: The 24 bits right after the pattern form the total count, most significant bit first. Each of these bits also appears on `ser_out` one clock after it is sampled.
- R4: After the header and until `OWN_FRAMES` frames have been received, `ser_out` is 1. A frame is a 0 start bit followed by `FRAME_BITS` data bits. Any number of 1 bits may come before a start bit.
- R5: When the last data bit of a frame is sampled, `frame_data` presents the frame, first-received bit in the most significant position, and `frame_vld` is 1 for exactly that one clock.
- R6: Once its own frames are complete, every later bit, start bits included, appears on `ser_out` one clock after it is sampled.
- R7: Sampled bits are numbered from 1, starting at the first clock edge after `rst_n` rises. `seq_start` rises at the edge that samples the bit whose number equals the captured count. This is true whether that bit lies in the frames or in the forwarded part.
- R8: `cfg_finished` rises one clock after `seq_start`, and `io_free` rises two clocks after it. All three then stay high until reset.
- R9: After start-up has begun, input bits are ignored: `ser_out` stays 1 and `frame_vld` stays 0, even if the bits would otherwise start new frames.
- R10: Two receivers fed the same input and reset produce the same `ser_out`, the same frames and the same `seq_start` on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit is sampled per rising edge |
| rst_n | input | 1 | Synchronous active-low restart to idle search |
| ser_in | input | 1 | Serial configuration input |
| ser_out | output | 1 | Registered serial output toward the next receiver |
| frame_data | output | FRAME_BITS | Most recently completed own frame |
| frame_vld | output | 1 | One-clock strobe marking a new `frame_data` |
| seq_start | output | 1 | Start-up has begun; count reached |
| cfg_finished | output | 1 | Second step of start-up, one clock after `seq_start` |
| io_free | output | 1 | I/O release, two clocks after `seq_start` |

## Verification
Every result lands on the edge that samples bit k, so the bench sets `ser_in` on a falling edge and reads all outputs at the next falling edge. For each position k it compares `ser_out` and `frame_vld` with tables built while composing the stream. `seq_start`, `cfg_finished` and `io_free` are expected from sample k = L, L+1 and L+2 respectively, where L is the total count written into the header. Three stream shapes place L at the end of the forwarded data, inside the second own frame, and on the very last own data bit. Random idle runs, frame contents and forward lengths vary the timing, and a second receiver on the same input is compared cycle by cycle.

// File: rtl/chain_ld_pkg.sv
// Shared constants and types for the serial chain loader.
// Assumes: the start pattern is fixed at four bits, matched oldest bit first.
package chain_ld_pkg;
    localparam int          PAT_BITS  = 4;
    localparam logic [3:0]  START_PAT = 4'b0010;

    // Where the current input bit belongs.
    typedef enum logic [1:0] {
        PH_HEADER = 2'd0,
        PH_OWN    = 2'd1,
        PH_FWD    = 2'd2,
        PH_HALT   = 2'd3
    } phase_t;

    // Header scanner sub-state.
    typedef enum logic {
        HS_HUNT  = 1'b0,
        HS_COUNT = 1'b1
    } hdr_state_t;
endpackage

// File: rtl/chain_hdr_scan.sv
// Header scanner: hunts for the start pattern, then shifts in the total count.
// Assumes: bit_en is low once start-up began. hdr_done stays set until reset.
module chain_hdr_scan
    import chain_ld_pkg::*;
#(
    parameter int LEN_BITS = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                ser_in,
    output logic                hdr_done,
    output logic [LEN_BITS-1:0] len_value
);
    localparam int CW = (LEN_BITS > 1) ? $clog2(LEN_BITS) : 1;

    hdr_state_t             state_q;
    logic [PAT_BITS-2:0]    pat_q;
    logic [LEN_BITS-1:0]    len_q;
    logic [CW-1:0]          idx_q;
    logic [PAT_BITS-1:0]    pat_window;

    assign pat_window = {pat_q, ser_in};
    assign len_value  = len_q;

    // Pattern hunt and count shift, one bit per enabled clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= HS_HUNT;
            pat_q    <= '1;
            len_q    <= '0;
            idx_q    <= '0;
            hdr_done <= 1'b0;
        end else if (bit_en && !hdr_done) begin
            case (state_q)
                HS_HUNT: begin
                    pat_q <= pat_window[PAT_BITS-2:0];
                    if (pat_window == START_PAT) begin
                        state_q <= HS_COUNT;
                        idx_q   <= '0;
                    end
                end
                default: begin
                    len_q <= {len_q[LEN_BITS-2:0], ser_in};
                    if (idx_q == CW'(LEN_BITS-1)) begin
                        hdr_done <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Once captured, the count never changes before reset.
    assert_len_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |=> (hdr_done && $stable(len_value)));

    // The header completes only from the count-shifting state.
    assert_hdr_from_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_done) |-> (state_q == HS_COUNT));
endmodule

// File: rtl/chain_frame_take.sv
// Own-frame collector: waits for a 0 start bit, gathers FRAME_BITS bits MSB
// first, strobes each frame, and flags completion after OWN_FRAMES frames.
// Assumes: FRAME_BITS >= 2. bit_en is high only after the header is done and
// before start-up.
module chain_frame_take #(
    parameter int FRAME_BITS = 8,
    parameter int OWN_FRAMES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_en,
    input  logic                  ser_in,
    output logic                  own_done,
    output logic [FRAME_BITS-1:0] frame_data,
    output logic                  frame_vld
);
    localparam int BW = $clog2(FRAME_BITS);
    localparam int FW = (OWN_FRAMES > 1) ? $clog2(OWN_FRAMES) : 1;

    logic                  busy_q;
    logic [BW-1:0]         bit_idx_q;
    logic [FRAME_BITS-1:0] shift_q;
    logic [FRAME_BITS-1:0] next_word;
    logic                  active;
    logic                  word_end;
    logic                  last_frame;

    assign active    = bit_en && !own_done;
    assign next_word = {shift_q[FRAME_BITS-2:0], ser_in};
    assign word_end  = active && busy_q && (bit_idx_q == BW'(FRAME_BITS-1));

    // Frame index only exists when more than one frame is owned.
    generate
        if (OWN_FRAMES > 1) begin : g_multi
            logic [FW-1:0] fidx_q;
            // Counts finished frames.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    fidx_q <= '0;
                end else if (word_end) begin
                    fidx_q <= fidx_q + 1'b1;
                end
            end
            assign last_frame = (fidx_q == FW'(OWN_FRAMES - 1));
        end else begin : g_single
            assign last_frame = 1'b1;
        end
    endgenerate

    // Start-bit hunt, bit gathering and frame hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            bit_idx_q  <= '0;
            shift_q    <= '0;
            frame_data <= '0;
            frame_vld  <= 1'b0;
            own_done   <= 1'b0;
        end else begin
            frame_vld <= 1'b0;
            if (active) begin
                if (!busy_q) begin
                    if (!ser_in) begin
                        busy_q    <= 1'b1;
                        bit_idx_q <= '0;
                    end
                end else begin
                    shift_q <= next_word;
                    if (word_end) begin
                        busy_q     <= 1'b0;
                        frame_data <= next_word;
                        frame_vld  <= 1'b1;
                        if (last_frame) begin
                            own_done <= 1'b1;
                        end
                    end else begin
                        bit_idx_q <= bit_idx_q + 1'b1;
                    end
                end
            end
        end
    end

    // A strobe lasts one clock; a start bit always separates two frames.
    assert_vld_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld);

    // Completion coincides with the strobe of the final frame.
    assert_done_with_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_done) |-> frame_vld);

    // Completion is sticky.
    assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        own_done |=> own_done);
endmodule

// File: rtl/chain_startup.sv
// Clock counter and start-up sequencer: counts sampled bits from reset
// release and begins a three-step start-up when the count equals the total.
// Assumes: len_valid is sticky and len_value is stable while it is high.
module chain_startup #(
    parameter int LEN_BITS = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                len_valid,
    input  logic [LEN_BITS-1:0] len_value,
    output logic                seq_start,
    output logic                cfg_finished,
    output logic                io_free
);
    logic [LEN_BITS-1:0] cnt_q;
    logic [LEN_BITS-1:0] cnt_next;

    assign cnt_next = cnt_q + 1'b1;

    // Bit counter and count match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            seq_start <= 1'b0;
        end else if (!seq_start) begin
            cnt_q <= cnt_next;
            if (len_valid && (cnt_next == len_value)) begin
                seq_start <= 1'b1;
            end
        end
    end

    // Two-step tail of the start-up sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_finished <= 1'b0;
            io_free      <= 1'b0;
        end else begin
            cfg_finished <= seq_start;
            io_free      <= cfg_finished;
        end
    end

    // Start-up begins exactly when the counter has reached the total.
    assert_start_on_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_start) |-> (cnt_q == len_value));

    // Second step follows the first by one clock.
    assert_finish_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_start) |=> $rose(cfg_finished));

    // Release follows the second step by one clock.
    assert_release_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_finished) |=> $rose(io_free));

    // Start-up, once begun, is held until reset.
    assert_start_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> seq_start);
endmodule

// File: rtl/serial_chain_loader.sv
// Serial chain configuration loader top. It routes each sampled bit to the
// header scanner, the own-frame collector or the forward path, drives the
// registered chain output, and hosts the start-up sequencer.
// Assumes: one bit per rising clk edge, and a synchronous active-low reset.
module serial_chain_loader
    import chain_ld_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int OWN_FRAMES = 3,
    parameter int LEN_BITS   = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_in,
    output logic                  ser_out,
    output logic [FRAME_BITS-1:0] frame_data,
    output logic                  frame_vld,
    output logic                  seq_start,
    output logic                  cfg_finished,
    output logic                  io_free
);
    logic                hdr_done;
    logic [LEN_BITS-1:0] len_value;
    logic                own_done;
    logic                bit_en;
    phase_t              phase;

    assign bit_en = !seq_start;

    // Classify the current bit from the sub-block completion flags.
    always_comb begin
        if (seq_start) begin
            phase = PH_HALT;
        end else if (!hdr_done) begin
            phase = PH_HEADER;
        end else if (!own_done) begin
            phase = PH_OWN;
        end else begin
            phase = PH_FWD;
        end
    end

    chain_hdr_scan #(
        .LEN_BITS (LEN_BITS)
    ) u_hdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .ser_in    (ser_in),
        .hdr_done  (hdr_done),
        .len_value (len_value)
    );

    chain_frame_take #(
        .FRAME_BITS (FRAME_BITS),
        .OWN_FRAMES (OWN_FRAMES)
    ) u_frames (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en && hdr_done),
        .ser_in     (ser_in),
        .own_done   (own_done),
        .frame_data (frame_data),
        .frame_vld  (frame_vld)
    );

    chain_startup #(
        .LEN_BITS (LEN_BITS)
    ) u_start (
        .clk          (clk),
        .rst_n        (rst_n),
        .len_valid    (hdr_done),
        .len_value    (len_value),
        .seq_start    (seq_start),
        .cfg_finished (cfg_finished),
        .io_free      (io_free)
    );

    // Chain output: copy header and surplus bits, hold high otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out <= 1'b1;
        end else begin
            case (phase)
                PH_HEADER, PH_FWD: ser_out <= ser_in;
                default:           ser_out <= 1'b1;
            endcase
        end
    end

    // Header and surplus bits reach the output one clock later.
    assert_copy_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_HEADER) || (phase == PH_FWD)) |=> (ser_out == $past(ser_in)));

    // Output is high while own frames are taken.
    assert_own_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_OWN) |=> ser_out);

    // After start-up the output stays high.
    assert_halt_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HALT) |=> ser_out);

    // No frame is delivered after start-up has begun.
    assert_halt_no_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seq_start) |-> !frame_vld);
endmodule

// File: tb/serial_chain_loader_test.sv
// Bench: composes streams with idle runs, header, own frames, surplus bits and
// a tail, then checks every sampled position against tables built alongside.
module serial_chain_loader_test;
    localparam int CLK_PERIOD = 10;
    localparam int FB         = 8;
    localparam int NOWN       = 3;
    localparam int LW         = 24;
    localparam int MAXB       = 400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_in = 1'b1;
    logic          ser_out, frame_vld, seq_start, cfg_finished, io_free;
    logic [FB-1:0] frame_data;
    logic          p_out, p_vld, p_start, p_fin, p_free;
    logic [FB-1:0] p_data;

    int checks = 0;
    int fails  = 0;

    logic          bits    [0:MAXB-1];
    logic          exp_out [0:MAXB-1];
    logic          exp_vld [0:MAXB-1];
    logic [FB-1:0] exp_dat [0:MAXB-1];
    int            region  [0:MAXB-1];
    int            pos;
    int            nbits;
    int            len_at;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_chain_loader #(.FRAME_BITS(FB), .OWN_FRAMES(NOWN), .LEN_BITS(LW)) uut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_out(ser_out),
        .frame_data(frame_data), .frame_vld(frame_vld), .seq_start(seq_start),
        .cfg_finished(cfg_finished), .io_free(io_free));

    serial_chain_loader #(.FRAME_BITS(FB), .OWN_FRAMES(NOWN), .LEN_BITS(LW)) peer (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_out(p_out),
        .frame_data(p_data), .frame_vld(p_vld), .seq_start(p_start),
        .cfg_finished(p_fin), .io_free(p_free));

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    function automatic string region_tag(input int r);
        case (r)
            0: return "R2 pattern/idle copy";
            1: return "R3 count copy";
            2: return "R4 own-frame high";
            3: return "R6 surplus copy";
            default: return "R9 ignored after start";
        endcase
    endfunction

    task automatic push(input logic b, input logic e, input int r);
        pos++;
        bits[pos]    = b;
        exp_out[pos] = e;
        region[pos]  = r;
    endtask

    // mode 0: count ends surplus data; 1: inside second own frame; 2: last own bit
    task automatic build(input int mode);
        int lpos, mid, lastown, gap, m;
        logic [FB-1:0] d;
        logic [31:0] rb;
        for (int i = 0; i < MAXB; i++) begin
            bits[i] = 1'b1; exp_out[i] = 1'b1; exp_vld[i] = 1'b0;
            exp_dat[i] = '0; region[i] = 4;
        end
        pos = 0;
        mid = 0;
        gap = $urandom_range(0, 4);
        for (int i = 0; i < gap; i++) push(1'b1, 1'b1, 0);
        if (mode == 0) begin
            // decoy bits that contain no start pattern (R2)
            push(0,0,0); push(0,0,0); push(1,1,0); push(1,1,0);
            push(1,1,0); push(0,0,0); push(1,1,0); push(1,1,0);
            push(1,1,0); push(1,1,0);
        end
        push(0,0,0); push(0,0,0); push(1,1,0); push(0,0,0);
        lpos = pos + 1;
        for (int i = 0; i < LW; i++) push(1'b0, 1'b0, 1);
        for (int f = 0; f < NOWN; f++) begin
            gap = $urandom_range(0, 2);
            for (int i = 0; i < gap; i++) push(1'b1, 1'b1, 2);
            push(1'b0, 1'b1, 2);
            d = FB'($urandom);
            for (int i = FB - 1; i >= 0; i--) push(d[i], 1'b1, 2);
            exp_vld[pos] = 1'b1;
            exp_dat[pos] = d;
            if (f == 1) mid = pos - 3;
        end
        lastown = pos;
        m = $urandom_range(8, 20);
        for (int i = 0; i < m; i++) begin
            rb = $urandom;
            push(rb[0], rb[0], 3);
        end
        len_at = (mode == 0) ? pos : (mode == 1) ? mid : lastown;
        // tail with start-like zeros, must be ignored (R9)
        for (int i = 0; i < 12; i++) push(logic'(i % 3 != 0), 1'b1, 4);
        nbits = pos;
        for (int i = 0; i < LW; i++) begin
            bits[lpos + i]    = len_at[LW - 1 - i];
            exp_out[lpos + i] = len_at[LW - 1 - i];
        end
        for (int k = len_at + 1; k < MAXB; k++) begin
            exp_out[k] = 1'b1; exp_vld[k] = 1'b0; region[k] = 4;
        end
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        ser_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(ser_out == 1'b1, "R1 reset ser_out", 32'(ser_out), 1);
        chk(frame_vld == 1'b0, "R1 reset frame_vld", 32'(frame_vld), 0);
        chk({seq_start, cfg_finished, io_free} == 3'b000, "R1 reset start flags",
            32'({seq_start, cfg_finished, io_free}), 0);
    endtask

    task automatic run_stream();
        for (int k = 1; k <= nbits + 3; k++) begin
            rst_n  = 1'b1;
            ser_in = (k <= nbits) ? bits[k] : 1'b1;
            @(negedge clk);
            chk(ser_out == exp_out[k], region_tag(region[k]), 32'(ser_out), 32'(exp_out[k]));
            chk(frame_vld == exp_vld[k], "R5 frame strobe", 32'(frame_vld), 32'(exp_vld[k]));
            if (exp_vld[k])
                chk(frame_data == exp_dat[k], "R5 frame data", 32'(frame_data), 32'(exp_dat[k]));
            chk(seq_start == (k >= len_at), "R7 start at count", 32'(seq_start), 32'(k >= len_at));
            chk(cfg_finished == (k >= len_at + 1), "R8 finish step",
                32'(cfg_finished), 32'(k >= len_at + 1));
            chk(io_free == (k >= len_at + 2), "R8 release step",
                32'(io_free), 32'(k >= len_at + 2));
            chk({p_out, p_vld, p_start} == {ser_out, frame_vld, seq_start} &&
                (!frame_vld || p_data == frame_data), "R10 parallel receivers agree",
                32'({p_out, p_vld, p_start}), 32'({ser_out, frame_vld, seq_start}));
        end
    endtask

    initial begin
        void'($urandom(32'd5179));
        do_reset();
        build(0); run_stream();
        do_reset();
        build(1); run_stream();
        do_reset();          // R1 after start-up had begun
        build(2); run_stream();
        for (int r = 0; r < 3; r++) begin
            do_reset();
            build(r % 3); run_stream();
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1 run hung actual=%0d expected=0", checks);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule